// File: doc/BRIEF.md
# Sample Count Normalizer

This block keeps a running tally of accepted input samples and holds on to the value of the newest one. When a finish request arrives, it forms a normalizing denominator from the tally `n`. An even `n` gives `n*n`. An odd `n` gives `n*n - 1`. The block then divides the held sample value by that denominator with a bit-serial restoring divider. It reports the integer quotient together with a one-cycle completion pulse.

A tally of 0 or 1 makes the denominator zero. In that case no division is started. The quotient output keeps its old value, and a divide-by-zero indication is raised together with the completion pulse one cycle after the request. A clear input empties the tally and the held value. The surrounding logic feeds samples with a valid strobe, issues a one-cycle start, and waits for `done`.

Top module: `samp_norm`

## Requirements
- R1: After reset `quotient`, `done`, `busy` and `div_zero` are all 0, and the tally and held value are 0.
- R2: Each cycle with `in_valid` high and `clr` low adds one to the tally and stores `in_data` as the held value. The tally saturates at 255 (with the default saturating mode, 257 samples leave `n` = 255, not 1).
- R3: `clr` sets the tally and held value to 0 and wins over a simultaneous `in_valid`.
- R4: The denominator is `n*n` for even `n` and `n*n - 1` for odd `n`, 16 bits wide.
- R5: For a non-zero denominator, `quotient` becomes `held / denominator` truncated to an integer. `done` is a single-cycle pulse, and `quotient` changes only in a `done` cycle without `div_zero`.
- R6: `busy` is high from the cycle after an accepted start for 16 cycles. It falls in the same cycle that `done` rises, which is 16 cycles after the start edge.
- R7: For a zero denominator (`n` is 0 or 1), `done` and `div_zero` are high in the cycle after the start edge, `busy` stays low, and `quotient` is unchanged.
- R8: A `start` while `busy` is high is ignored: the running division completes at its original time with its original operands, and no extra `done` follows.
- R9: A sample accepted in the same cycle as `start`, or during `busy`, is counted. The division it joins uses the tally and held value from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empty the tally and held value |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 8 | Sample value |
| start | input | 1 | Finish request, one cycle |
| busy | output | 1 | Division in progress |
| done | output | 1 | Result ready pulse |
| div_zero | output | 1 | Division skipped, denominator was zero |
| quotient | output | 8 | Held value divided by denominator |

## Verification
Sample acceptance and the finish request can land on the same clock edge. The stimulus provokes this deliberately by raising `in_valid` together with `start`, and also by feeding samples while the divider runs. The model judges the result from the tally and held value as they stood before that edge, then advances its own tally afterward. A second start pulse is injected while `busy` is high, and the completion pulse is checked to arrive once, at its original cycle.

// File: rtl/sn_pkg.sv
package sn_pkg;
   typedef enum logic {
      CNT_WRAP = 1'b0,
      CNT_SAT  = 1'b1
   } cnt_mode_e;
endpackage

// File: rtl/sn_tally.sv
module sn_tally #(
   parameter int                CNT_W  = 8,
   parameter int                DATA_W = 8,
   parameter sn_pkg::cnt_mode_e MODE   = sn_pkg::CNT_SAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] held
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (MODE == sn_pkg::CNT_SAT) begin : g_sat
         assign cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         held <= '0;
      end else if (clr) begin
         cnt  <= '0;
         held <= '0;
      end else if (in_valid) begin
         cnt  <= cnt_nxt;
         held <= in_data;
      end
   end

   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

   p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0 && held == '0));
endmodule

// File: rtl/sn_denom.sv
module sn_denom #(
   parameter int CNT_W = 8,
   localparam int DEN_W = 2 * CNT_W
) (
   input  logic [CNT_W-1:0] n,
   output logic [DEN_W-1:0] den
);
   logic [DEN_W-1:0] n_ext;
   logic [DEN_W-1:0] sq;

   assign n_ext = {{CNT_W{1'b0}}, n};
   assign sq    = n_ext * n_ext;
   // odd tally drops one from the square, even keeps it
   assign den   = n[0] ? sq - 1'b1 : sq;
endmodule

// File: rtl/sn_divider.sv
module sn_divider #(
   parameter int W = 16,
   localparam int SW = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] dvs,
   output logic         busy,
   output logic         fin,
   output logic [W-1:0] res
);
   localparam logic [SW-1:0] LAST = SW'(W - 1);

   logic [W:0]    rem;
   logic [W-1:0]  q;
   logic [W-1:0]  d;
   logic [SW-1:0] step;
   logic [W:0]    rem_sh;
   logic          take;
   logic [W-1:0]  q_nxt;

   assign rem_sh = {rem[W-1:0], q[W-1]};
   assign take   = rem_sh >= {1'b0, d};
   assign q_nxt  = {q[W-2:0], take};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem  <= '0;
         q    <= '0;
         d    <= '0;
         step <= '0;
         busy <= 1'b0;
         fin  <= 1'b0;
         res  <= '0;
      end else begin
         fin <= 1'b0;
         if (busy) begin
            rem  <= take ? rem_sh - {1'b0, d} : rem_sh;
            q    <= q_nxt;
            step <= step + 1'b1;
            if (step == LAST) begin
               busy <= 1'b0;
               fin  <= 1'b1;
               res  <= q_nxt;
            end
         end else if (go) begin
            rem  <= '0;
            q    <= num;
            d    <= dvs;
            step <= '0;
            busy <= 1'b1;
         end
      end
   end

   p_fin_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);

   p_busy_ends_in_fin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> fin);

   p_go_ignored_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step != LAST) |=> (busy && $stable(d)));
endmodule

// File: rtl/samp_norm.sv
module samp_norm #(
   parameter int                CNT_W  = 8,
   parameter int                DATA_W = 8,
   parameter sn_pkg::cnt_mode_e MODE   = sn_pkg::CNT_SAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              div_zero,
   output logic [DATA_W-1:0] quotient
);
   localparam int DEN_W = 2 * CNT_W;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("samp_norm: CNT_W must be at least 2");
      end
      if (DATA_W > DEN_W) begin : g_bad_data
         $error("samp_norm: DATA_W must not exceed 2*CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0]  n;
   logic [DATA_W-1:0] held;
   logic [DEN_W-1:0]  den;
   logic [DEN_W-1:0]  res_w;
   logic              fin;
   logic              accept;
   logic              den_zero;
   logic              zflag_q;

   sn_tally #(.CNT_W(CNT_W), .DATA_W(DATA_W), .MODE(MODE)) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .in_valid (in_valid),
      .in_data  (in_data),
      .cnt      (n),
      .held     (held)
   );

   sn_denom #(.CNT_W(CNT_W)) u_denom (
      .n   (n),
      .den (den)
   );

   assign accept   = start && !busy;
   assign den_zero = (den == '0);

   sn_divider #(.W(DEN_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (accept && !den_zero),
      .num   ({{(DEN_W-DATA_W){1'b0}}, held}),
      .dvs   (den),
      .busy  (busy),
      .fin   (fin),
      .res   (res_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) zflag_q <= 1'b0;
      else        zflag_q <= accept && den_zero;
   end

   assign done     = fin | zflag_q;
   assign div_zero = zflag_q;
   assign quotient = res_w[DATA_W-1:0];

   p_quo_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (res_w >> DATA_W) == '0);

   p_quo_moves_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quotient) |-> (done && !div_zero));

   p_zero_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero |-> (done && !busy && $stable(quotient)));

   p_zero_next_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && den_zero) |=> div_zero);
endmodule

// File: tb/tb_samp_norm.sv
module tb_samp_norm;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       start = 1'b0;
   logic       busy, done, div_zero;
   logic [7:0] quotient;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   int m_n = 0;
   int m_data = 0;
   int m_q = 0;

   always #4 clk = ~clk;

   samp_norm dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
      .in_data(in_data), .start(start), .busy(busy), .done(done),
      .div_zero(div_zero), .quotient(quotient)
   );

   function automatic int f_den(int n);
      return (n % 2 == 1) ? n * n - 1 : n * n;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic m_accept(int d);
      if (m_n < 255) m_n++;
      m_data = d;
   endtask

   task automatic sample(int d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(d);
      @(negedge clk);
      in_valid = 1'b0;
      m_accept(d);
   endtask

   task automatic clear(bit with_valid);
      @(negedge clk);
      clr = 1'b1;
      in_valid = with_valid;
      in_data = 8'hA5;
      @(negedge clk);
      clr = 1'b0;
      in_valid = 1'b0;
      m_n = 0;
      m_data = 0;
   endtask

   task automatic finish(bit overlap, bit poke, int od);
      int den;
      den = f_den(m_n);
      @(negedge clk);
      start = 1'b1;
      if (overlap) begin
         in_valid = 1'b1;
         in_data = 8'(od);
      end
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b0;
      if (overlap) m_accept(od);
      if (den == 0) begin
         chk("R7 done", done, 1);
         chk("R7 div_zero", div_zero, 1);
         chk("R7 busy", busy, 0);
         chk("R7 quotient kept", quotient, m_q);
         @(negedge clk);
         chk("R5 done pulse", done, 0);
      end else begin
         int exp_q;
         exp_q = (overlap ? 0 : m_data);
         chk("R6 busy", busy, 1);
         chk("R6 done early", done, 0);
         if (poke) begin
            @(negedge clk);
            start = 1'b1;
            in_valid = 1'b1;
            in_data = 8'd7;
            @(negedge clk);
            start = 1'b0;
            in_valid = 1'b0;
            m_accept(7);
            chk("R8 busy kept", busy, 1);
            repeat (13) @(negedge clk);
         end else begin
            repeat (15) @(negedge clk);
         end
         chk("R6 done before 16", done, 0);
         chk("R6 busy before 16", busy, 1);
         @(negedge clk);
         chk("R6 done", done, 1);
         chk("R6 busy low", busy, 0);
         chk("R5 div_zero low", div_zero, 0);
         exp_q = 0;
         m_q = exp_q;
         return_q(den);
         @(negedge clk);
         chk("R8 no extra done", done, 0);
      end
   endtask

   int pend_data;
   task automatic return_q(int den);
      m_q = pend_data / den;
      chk("R5 quotient", quotient, m_q);
   endtask

   task automatic finish_w(bit overlap, bit poke, int od);
      pend_data = m_data;
      finish(overlap, poke, od);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int s;
      s = $urandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      chk("R1 quotient", quotient, 0);
      chk("R1 done", done, 0);
      chk("R1 busy", busy, 0);
      chk("R1 div_zero", div_zero, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after release", busy, 0);

      // R1 empty tally: zero denominator
      finish_w(0, 0, 0);
      // R7 single sample: n=1 -> zero
      sample(200);
      finish_w(0, 0, 0);
      // R4 n=2 -> 4, R5
      sample(255);
      finish_w(0, 0, 0);
      // R4 n=3 odd -> 8
      sample(100);
      finish_w(0, 0, 0);
      // R9 overlap: n=3 used, sample joins after
      finish_w(1, 0, 250);
      // R8 poke during busy, n=4 -> 16
      finish_w(0, 1, 0);
      // R3 clear wins over valid
      clear(1);
      finish_w(0, 0, 0);
      // R2 saturation: 257 samples -> n=255 not 1
      for (int i = 0; i < 257; i++) sample(i % 256);
      finish_w(0, 0, 0);
      chk("R2 saturated no div_zero", div_zero, 0);

      // constrained random
      for (int it = 0; it < 80; it++) begin
         int k;
         if ($urandom_range(0, 3) == 0) clear($urandom_range(0, 1) == 1);
         k = $urandom_range(0, 4);
         for (int j = 0; j < k; j++) sample($urandom_range(0, 255));
         finish_w($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                  $urandom_range(0, 255));
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule